// File: doc/BRIEF.md
# Modem Status Register with Loopback View

This block keeps the eight-bit modem status register of a serial port. Four incoming modem lines (clear-to-send, data-set-ready, carrier detect and ring indicator) pass through a two-flop synchronizer. The synchronized levels are then held in the upper half of the register. Each clock, the new levels are compared with the held ones. A difference sets a sticky change flag in the lower half of the register. The ring line is the exception: its flag is set only when ring goes from high to low.

Software reads the register through a read strobe. The read data is available in the same cycle as the strobe, and the change flags clear at the following clock edge. A change that lands on that same edge is still recorded. When the loop bit of the modem control value is set, the read data shows a remapped copy of the control outputs instead of the external lines, and a read does not clear the change flags. A pending flag tells the interrupt arbiter that at least one change flag is set.

Top module: `modem_status_unit`

## Requirements
- R1: In the first cycle after reset, with the loop bit clear, `rd_data_o` reads 0xB0 (carrier, data-set-ready and clear-to-send set; ring and all change flags clear) and `pend_o` is low.
- R2: Status bit positions: carrier detect at bit 7, ring at bit 6, data-set-ready at bit 5, clear-to-send at bit 4. Each bit follows its external line.
- R3: A change in either direction of carrier detect, data-set-ready or clear-to-send sets its change flag at bit 3, bit 1 or bit 0 respectively.
- R4: The ring change flag at bit 2 is set only by a falling ring line. A rising ring line leaves bit 2 clear.
- R5: A change flag stays set after its line returns to the earlier level, until the register is read.
- R6: With the loop bit clear, a read strobe returns the current register value in the same cycle. The change flags are zero from the next cycle on, and the status bits are not affected.
- R7: A line change that is recorded on the same clock edge as a read clear still sets its change flag.
- R8: `pend_o` is high exactly when at least one of bits 3..0 is set.
- R9: When `mcr_i[4]` (loop) is set, `rd_data_o` holds `mcr_i[3:2]` in bits 7:6, `mcr_i[0]` in bit 5, `mcr_i[1]` in bit 4, and zero in bits 3..0. A read strobe in this mode leaves the change flags untouched.
- R10: An external line change is first visible at `rd_data_o` after the third rising clock edge following it, and is not visible after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_cts_i | input | 1 | External clear-to-send line, asynchronous |
| line_dsr_i | input | 1 | External data-set-ready line, asynchronous |
| line_dcd_i | input | 1 | External carrier-detect line, asynchronous |
| line_ri_i | input | 1 | External ring-indicator line, asynchronous |
| mcr_i | input | 5 | Modem control value; bit 4 loop, bit 3 out2, bit 2 out1, bit 1 rts, bit 0 dtr |
| rd_i | input | 1 | Register read strobe, one cycle per read |
| rd_data_o | output | 8 | Register read data |
| pend_o | output | 1 | At least one change flag is set |

## Verification
A line change takes three rising edges to appear: two synchronizer flops and then the register. The bench drives inputs on falling edges and samples exactly three edges later, and it also samples after two edges to confirm that nothing shows early. The loopback view is combinational on `mcr_i`, so it is checked one falling edge after it is driven. A read clear shows at the edge after the strobe, and the bench checks the read value in the strobe cycle and the cleared value one cycle later. In the random phase, a bench model runs the same three-stage timing every cycle and compares the read data and the pending flag on every falling edge.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NLINES = 4;
    localparam int MCR_W  = 5;
    localparam int REG_W  = 2 * NLINES;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    localparam modem_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

    // change flags between old and new samples; ring flags only on a 1->0 edge
    function automatic modem_lines_t change_flags(modem_lines_t nw, modem_lines_t old);
        modem_lines_t f;
        f     = nw ^ old;
        f.ri  = old.ri & ~nw.ri;
        return f;
    endfunction

    // control outputs as seen through the status register in loop mode
    function automatic logic [REG_W-1:0] loop_view(logic [MCR_W-1:0] mcr);
        logic [REG_W-1:0] v;
        v      = '0;
        v[7:6] = mcr[3:2];
        v[5]   = mcr[0];
        v[4]   = mcr[1];
        return v;
    endfunction
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= RST_VAL;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  modem_lines_t smp_i,
    input  logic         clr_i,
    output modem_lines_t lines_o,
    output modem_lines_t delta_o
);
    modem_lines_t lines_q, delta_q, delta_d;

    always_comb begin
        delta_d = clr_i ? '0 : delta_q;
        delta_d = delta_d | change_flags(smp_i, lines_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= LINES_RST;
            delta_q <= '0;
        end else begin
            lines_q <= smp_i;
            delta_q <= delta_d;
        end
    end

    assign lines_o = lines_q;
    assign delta_o = delta_q;

    assert_ring_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_q.ri) |-> ($past(lines_q.ri) && !lines_q.ri));

    assert_cts_change_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(delta_q.cts) |-> (lines_q.cts != $past(lines_q.cts)));

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_i && smp_i == lines_q) |=> (delta_q == '0));
endmodule

// File: rtl/msr_readmux.sv
module msr_readmux
    import msr_pkg::*;
(
    input  logic [MCR_W-1:0] mcr_i,
    input  modem_lines_t     lines_i,
    input  modem_lines_t     delta_i,
    output logic [REG_W-1:0] rd_data_o
);
    always_comb begin
        if (mcr_i[MCR_W-1]) rd_data_o = loop_view(mcr_i);
        else                rd_data_o = {lines_i, delta_i};
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_cts_i,
    input  logic             line_dsr_i,
    input  logic             line_dcd_i,
    input  logic             line_ri_i,
    input  logic [MCR_W-1:0] mcr_i,
    input  logic             rd_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             pend_o
);
    modem_lines_t raw, smp, lines, delta;
    logic         loop_mode, rd_clr;

    assign raw       = '{dcd: line_dcd_i, ri: line_ri_i, dsr: line_dsr_i, cts: line_cts_i};
    assign loop_mode = mcr_i[MCR_W-1];
    assign rd_clr    = rd_i & ~loop_mode;

    msr_sync #(.W(NLINES), .STAGES(2), .RST_VAL(LINES_RST)) u_sync (
        .clk(clk), .rst(rst), .async_i(raw), .sync_o(smp)
    );

    msr_delta u_delta (
        .clk(clk), .rst(rst), .smp_i(smp), .clr_i(rd_clr),
        .lines_o(lines), .delta_o(delta)
    );

    msr_readmux u_mux (
        .mcr_i(mcr_i), .lines_i(lines), .delta_i(delta), .rd_data_o(rd_data_o)
    );

    assign pend_o = |delta;

    assert_pend_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o) |-> $past(smp != lines));

    assert_loop_low_R9: assert property (@(posedge clk) disable iff (rst)
        loop_mode |-> (rd_data_o[3:0] == 4'b0));

    assert_loop_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_i && loop_mode && pend_o) |=> pend_o);
endmodule

// File: tb/modem_status_unit_bench.sv
module modem_status_unit_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       cts, dsr, dcd, ri;
    logic [4:0] mcr;
    logic       rd;
    logic [7:0] rdata;
    logic       pend;
    int         total = 0;
    int         bad   = 0;
    logic       done  = 1'b0;

    always #4 clk = ~clk;

    modem_status_unit u_modem_status_unit (
        .clk(clk), .rst(rst),
        .line_cts_i(cts), .line_dsr_i(dsr), .line_dcd_i(dcd), .line_ri_i(ri),
        .mcr_i(mcr), .rd_i(rd), .rd_data_o(rdata), .pend_o(pend)
    );

    function automatic logic [3:0] flags_of(logic [3:0] nw, logic [3:0] old);
        logic [3:0] x;
        x    = nw ^ old;
        x[2] = old[2] & ~nw[2];
        return x;
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic check1(string req, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] m1, m2, mst, md, nx, lin;
        logic       r;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; cts = 1; dsr = 1; dcd = 1; ri = 0; mcr = 5'h08; rd = 0;
        step(3);
        rst = 1'b0;
        step(1);
        check8("R1 reset value", rdata, 8'hB0);
        check1("R1 reset pend", pend, 1'b0);

        // clear-to-send falls: hidden after two edges, visible after three
        cts = 0;
        step(2);
        check8("R10 not yet visible", rdata, 8'hB0);
        step(1);
        check8("R2 R3 cts fall", rdata, 8'hA1);
        check1("R8 pend set", pend, 1'b1);

        rd = 1;
        #1 check8("R6 read same cycle", rdata, 8'hA1);
        step(1); rd = 0;
        check8("R6 cleared after read", rdata, 8'hA0);
        check1("R8 pend clear", pend, 1'b0);

        ri = 1;
        step(3);
        check8("R4 ring rise no flag", rdata, 8'hE0);
        ri = 0;
        step(3);
        check8("R4 ring fall flag", rdata, 8'hA4);
        rd = 1; step(1); rd = 0;
        check8("R6 clear ring flag", rdata, 8'hA0);

        dsr = 0; step(1); dsr = 1;
        step(4);
        check8("R5 sticky dsr", rdata, 8'hA2);
        rd = 1; step(1); rd = 0;
        check8("R6 clear dsr flag", rdata, 8'hA0);

        cts = 1; step(3);
        check8("R3 cts rise", rdata, 8'hB1);
        dcd = 0;
        step(2);
        rd = 1;
        #1 check8("R7 value before edge", rdata, 8'hB1);
        step(1); rd = 0;
        check8("R7 change kept on clear", rdata, 8'h38);

        mcr = 5'b10110;
        step(1);
        check8("R9 loop map a", rdata, 8'h50);
        check1("R8 pend in loop", pend, 1'b1);
        rd = 1; step(1); rd = 0;
        mcr = 5'b11001;
        step(1);
        check8("R9 loop map b", rdata, 8'hA0);
        mcr = 5'b00000;
        step(1);
        check8("R9 loop read did not clear", rdata, 8'h38);
        rd = 1; step(1); rd = 0;
        check8("R6 final clear", rdata, 8'h30);

        // random phase against a cycle model
        lin = {dcd, ri, dsr, cts};
        m1 = lin; m2 = lin; mst = lin; md = 4'h0;
        for (int i = 0; i < 3000; i++) begin
            check8("R2 R3 R5 R6 R7 random", rdata, {mst, md});
            check1("R8 random pend", pend, |md);
            if ($urandom_range(3) == 0) lin = lin ^ 4'($urandom_range(15));
            r = ($urandom_range(4) == 0);
            {dcd, ri, dsr, cts} = lin;
            rd  = r;
            mcr = 5'($urandom_range(15));
            nx  = (r ? 4'h0 : md) | flags_of(m2, mst);
            md  = nx; mst = m2; m2 = m1; m1 = lin;
            step(1);
        end
        rd = 0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule